// File: doc/BRIEF.md
# Ones-Density Violation Monitor

This block watches a serial received line bit stream, one bit per accepted strobe, and decides whether the stream still carries enough ones for a receiver to hold clock recovery. It applies two separate tests to every accepted bit. The first is a zero-run test: a run of sixteen or more zeros is a violation. The second is a sliding-window density test: for every n from 1 to 23, the newest 8*(n+1) bits must hold at least n ones.

When either test fails, a level status goes high. The status does not drop when the tests pass again. It clears only after the stream has delivered 23 ones in a row. A one-cycle interrupt pulse marks each rise of the status, and nothing marks its fall.

Bits arrive at any rate, set by a valid strobe. Cycles without the strobe leave every piece of state unchanged.

Top module: `pdv_monitor`

## Requirements
- R1: After reset `viol` and `viol_irq` are 0, and the bit history counts as all ones. The bits before the first accepted one therefore never cause a violation.
- R2: The 16th consecutive accepted zero sets `viol`. A run of 15 zeros followed by a one does not.
- R3: For each n in 1..23, if the newest 8*(n+1) accepted bits, including the current one, hold fewer than n ones, `viol` is set. Windows are counted in accepted bits only.
- R4: Once set, `viol` stays 1 until 23 consecutive ones have been accepted. Any accepted zero while `viol` is 1 restarts that count. `viol` clears on the clock edge that accepts the 23rd one.
- R5: `viol_irq` is 1 for exactly the one cycle that follows each 0-to-1 transition of `viol`. The pulse is registered on the same edge that raises `viol`.
- R6: `viol_irq` stays 0 when `viol` falls, and also while `viol` stays at 1.
- R7: A cycle with `bit_vld` at 0 changes neither `viol` nor the history, whatever the value of `bit_in`.
- R8: Both tests and the recovery count are evaluated on the clock edge that accepts a bit. The effect of that bit shows on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Received line bit |
| bit_vld | input | 1 | Strobe: `bit_in` is accepted on this edge |
| viol | output | 1 | Density violation status (level) |
| viol_irq | output | 1 | One-cycle pulse on the rise of `viol` |

## Verification
The zero-run test and the 16-bit density window can both fail on the same bit. This happens when a stream of ones is followed by exactly sixteen zeros. The bench drives this and expects `viol` to rise once, with a single interrupt pulse.

A second collision is a zero arriving on the edge where the recovery count would otherwise finish. The bench sends 22 ones and then a zero, and expects `viol` to stay set with no new pulse.

A behavioural model is compared with the block on every cycle. The model keeps the history in a queue and recounts each window from scratch.

// File: rtl/pdv_pkg.sv
package pdv_pkg;

  // Length in bits of the density window that must hold n ones.
  function automatic int win_len(input int step, input int n);
    return step * (n + 1);
  endfunction

  // Ones required in the window of index n.
  function automatic int ones_needed(input int n);
    return n;
  endfunction

  // Counter width able to hold the value max_val.
  function automatic int cnt_width(input int max_val);
    return $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/pdv_history.sv
module pdv_history #(
  parameter int WIN_STEP = 8,
  parameter int N_MAX    = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             bit_vld,
  output logic [N_MAX-1:0] win_fail
);
  localparam int HIST_LEN = pdv_pkg::win_len(WIN_STEP, N_MAX);
  localparam int CNT_W    = pdv_pkg::cnt_width(HIST_LEN);

  logic [HIST_LEN-1:0] hist;  // bit 0 is the newest accepted bit

  always_ff @(posedge clk) begin
    if (!rst_n)       hist <= '1;
    else if (bit_vld) hist <= {hist[HIST_LEN-2:0], bit_in};
  end

  // Each window keeps a running ones count. The count moves by the
  // incoming bit minus the bit that drops off the window's far end.
  for (genvar k = 0; k < N_MAX; k++) begin : g_win
    localparam int WLEN = pdv_pkg::win_len(WIN_STEP, k + 1);
    localparam int NEED = pdv_pkg::ones_needed(k + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             leaving;

    assign leaving = hist[WLEN-1];

    always_comb cnt_nxt = cnt + CNT_W'(bit_in) - CNT_W'(leaving);

    always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= CNT_W'(WLEN);
      else if (bit_vld) cnt <= cnt_nxt;
    end

    assign win_fail[k] = bit_vld && (cnt_nxt < CNT_W'(NEED));

    // R3: a window count can never exceed the window length
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(WLEN));
  end

  // R7: the history holds while no bit is accepted
  a_r7_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(hist));

endmodule

// File: rtl/pdv_zero_run.sv
module pdv_zero_run #(
  parameter int ZRUN_LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic zrun_fail
);
  localparam int ZC_W = pdv_pkg::cnt_width(ZRUN_LIMIT + 1);

  logic [ZC_W-1:0] zcnt;  // saturates at ZRUN_LIMIT+1

  always_ff @(posedge clk) begin
    if (!rst_n) zcnt <= '0;
    else if (bit_vld) begin
      if (bit_in)                            zcnt <= '0;
      else if (zcnt <= ZC_W'(ZRUN_LIMIT))    zcnt <= zcnt + 1'b1;
    end
  end

  // Fails on the zero that makes the run longer than the limit.
  assign zrun_fail = bit_vld && !bit_in && (zcnt >= ZC_W'(ZRUN_LIMIT));

  // R2: the run counter stays within its saturation range
  a_r2_zcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    zcnt <= ZC_W'(ZRUN_LIMIT + 1));

  // R2: an accepted one always ends a run
  a_r2_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && bit_in) |=> (zcnt == '0));

endmodule

// File: rtl/pdv_recovery.sv
module pdv_recovery #(
  parameter int RECOVER_ONES = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic set_evt,
  output logic viol,
  output logic viol_irq
);
  localparam int RUN_W = pdv_pkg::cnt_width(RECOVER_ONES);

  logic [RUN_W-1:0] ones_run;
  logic             rise;
  logic             clear;

  assign rise  = bit_vld && !viol && set_evt;
  assign clear = bit_vld && viol && bit_in && (ones_run == RUN_W'(RECOVER_ONES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol     <= 1'b0;
      viol_irq <= 1'b0;
      ones_run <= '0;
    end else begin
      viol_irq <= rise;
      if (rise) begin
        viol     <= 1'b1;
        ones_run <= '0;
      end else if (clear) begin
        viol     <= 1'b0;
        ones_run <= '0;
      end else if (bit_vld && viol) begin
        ones_run <= bit_in ? ones_run + 1'b1 : '0;
      end
    end
  end

  // R5: a pulse only follows a rise of the status
  a_r5_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    viol_irq |-> (viol && !$past(viol)));

  // R5: a pulse lasts a single cycle
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    viol_irq |=> !viol_irq);

  // R6: no pulse when the status falls
  a_r6_no_fall_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(viol) |-> !viol_irq);

  // R4: the status clears only on an accepted one
  a_r4_clear_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(viol) |-> $past(bit_vld && bit_in));

  // R7: the status holds while no bit is accepted
  a_r7_viol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(viol));

endmodule

// File: rtl/pdv_monitor.sv
module pdv_monitor #(
  parameter int WIN_STEP     = 8,
  parameter int N_MAX        = 23,
  parameter int ZRUN_LIMIT   = 15,
  parameter int RECOVER_ONES = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic viol,
  output logic viol_irq
);
  logic [N_MAX-1:0] win_fail;
  logic             dens_fail;
  logic             zrun_fail;
  logic             set_evt;

  pdv_history #(.WIN_STEP(WIN_STEP), .N_MAX(N_MAX)) u_hist (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .win_fail(win_fail)
  );

  pdv_zero_run #(.ZRUN_LIMIT(ZRUN_LIMIT)) u_zrun (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .zrun_fail(zrun_fail)
  );

  assign dens_fail = |win_fail;
  assign set_evt   = dens_fail | zrun_fail;

  pdv_recovery #(.RECOVER_ONES(RECOVER_ONES)) u_rec (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .set_evt(set_evt), .viol(viol), .viol_irq(viol_irq)
  );

  // R2: an over-long zero run leaves the status set on the next cycle
  a_r2_zero_run_sets: assert property (@(posedge clk) disable iff (!rst_n)
    zrun_fail |=> viol);

  // R3: a density failure leaves the status set on the next cycle
  a_r3_density_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dens_fail |=> viol);

  // R8: a test can only fail on a cycle that accepts a bit
  a_r8_fail_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |-> bit_vld);

endmodule

// File: tb/pdv_monitor_tb.sv
module pdv_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b1;
  logic bit_vld = 1'b0;
  logic viol, viol_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  bit mhist[$];
  int mzrun;
  int mrun;
  bit mviol, mirq;
  bit saw_viol;

  always #5ns clk = ~clk;

  pdv_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .viol(viol), .viol_irq(viol_irq)
  );

  task automatic model_reset();
    mhist.delete();
    for (int i = 0; i < 192; i++) mhist.push_back(1'b1);
    mzrun = 0; mrun = 0; mviol = 0; mirq = 0;
  endtask

  task automatic model_step(input bit b, input bit v);
    bit fail;
    mirq = 0;
    if (!v) return;
    mhist.push_front(b);
    void'(mhist.pop_back());
    mzrun = b ? 0 : mzrun + 1;
    fail = (mzrun > 15);
    for (int n = 1; n <= 23; n++) begin
      int ones = 0;
      for (int i = 0; i < 8 * (n + 1); i++) ones += mhist[i];
      if (ones < n) fail = 1;
    end
    if (!mviol) begin
      if (fail) begin mviol = 1; mirq = 1; mrun = 0; end
    end else if (b) begin
      mrun++;
      if (mrun == 23) begin mviol = 0; mrun = 0; end
    end else mrun = 0;
  endtask

  task automatic chk(input string t, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  task automatic step(input bit b, input bit v);
    bit_in = b; bit_vld = v;
    @(posedge clk);
    model_step(b, v);
    @(negedge clk);
    chk({tag, " viol"}, viol, mviol);
    chk(mirq ? "R5 irq" : "R6 irq", viol_irq, mirq);
    if (viol) saw_viol = 1;
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 viol", viol, 1'b0);
    chk("R1 irq", viol_irq, 1'b0);

    // R1: zero run shorter than the limit right after reset
    tag = "R1";
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1);
    chk("R1 no viol after 15 zeros", viol, 1'b0);
    step(1'b1, 1'b1);

    // R2: 15 zeros then a one do not set; 16 zeros do
    tag = "R2";
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk("R2 15 zeros", viol, 1'b0);
    for (int i = 0; i < 24; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1);
    chk("R2 before 16th", viol, 1'b0);
    step(1'b0, 1'b1);  // both rules fail on this bit
    chk("R2 16th zero sets", viol, 1'b1);
    chk("R5 single pulse", viol_irq, 1'b1);
    step(1'b0, 1'b1);
    chk("R6 no pulse while set", viol_irq, 1'b0);

    // R4: 22 ones then a zero keep it set; 23 ones clear it
    tag = "R4";
    for (int i = 0; i < 22; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    chk("R4 zero restarts count", viol, 1'b1);
    for (int i = 0; i < 22; i++) step(1'b1, 1'b1);
    chk("R4 22 ones not enough", viol, 1'b1);
    step(1'b1, 1'b1);
    chk("R4 23rd one clears", viol, 1'b0);
    chk("R6 no pulse on fall", viol_irq, 1'b0);

    // R7: idle cycles change nothing, with gaps inside a zero run
    tag = "R7";
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
    chk("R7 idle zeros ignored", viol, 1'b0);
    for (int i = 0; i < 15; i++) begin step(1'b0, 1'b1); step(1'b0, 1'b0); end
    chk("R7 gaps not counted", viol, 1'b0);
    step(1'b0, 1'b1);
    chk("R7 16th accepted zero", viol, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    chk("R7 idle ones ignored", viol, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1);

    // R3: density-only failure, one 1 in every 16 bits
    tag = "R3";
    saw_viol = 0;
    for (int r = 0; r < 20; r++) begin
      step(1'b1, 1'b1);
      for (int i = 0; i < 15; i++) step(1'b0, 1'b1);
    end
    chk("R3 sparse stream flagged", saw_viol, 1'b1);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1);

    // R8: mixed random stream compared on every cycle
    tag = "R8";
    for (int blk = 0; blk < 30; blk++) begin
      int pz = 30 + (blk % 6) * 13;
      for (int i = 0; i < 100; i++)
        step(($urandom % 100) >= pz, ($urandom % 100) < 85);
    end
    finish_run();
  end
endmodule